// File: doc/BRIEF.md
# Parity-Checked Scan Instruction Register and Decoder

This block holds the 8-bit instruction of a boundary-scan test port and turns it into two control indications: which data register sits between TDI and TDO, and which operating mode the device is in. The port's state machine provides the capture, shift and update strobes. The block loads a fixed status pattern on capture and shifts a new opcode in from TDI, least significant bit first, while the old contents leave on TDO. On the falling edge of TCK during update, it latches and decodes the opcode.

The top bit of every opcode is a parity bit: a valid opcode has an even number of ones across all eight bits. Some opcodes have a defined meaning. Any other opcode with valid parity, including the four that name features this device does not provide, runs as bypass in normal mode. An opcode with odd parity decodes the same way, and a flag reports the parity failure. A synchronous reset restores the identification instruction in normal mode.

Top module: `scan_instr_decoder`

## Requirements
- R1: On a rising TCK edge with `capture_ir` high, the shift stage loads 8'b00000001, so the next eight shifts put the bits 1,0,0,0,0,0,0,0 on `tdo` in that order.
- R2: On a rising TCK edge with `shift_ir` high and `capture_ir` low, the stage moves one place toward its LSB and takes `tdi` into bit 7. `tdo` always shows bit 0, so a second 8-bit shift with no capture returns the word shifted in by the first.
- R3: `dsel`, `mode` and `parity_ok` change only on a falling TCK edge where `update_ir` is high. Capture and shift activity leaves them unchanged.
- R4: With `rst` high at a TCK edge, the shift stage takes the capture pattern. On a falling edge the outputs become `dsel`=2 (identification), `mode`=0 (normal) and `parity_ok`=1.
- R5: `parity_ok` is 1 exactly when the latched opcode has an even count of ones.
- R6: The opcodes below select the boundary register (`dsel`=1). 0x00 and 0x8B give test mode (`mode`=1). 0x82, 0x0A and 0x0C give normal mode (`mode`=0).
- R7: The opcodes below select bypass (`dsel`=0). 0x06 gives modified test (`mode`=2). 0x87 and 0x8D give test. 0x09 gives normal.
- R8: 0x81 selects identification (`dsel`=2) in normal mode. 0x8E (normal) and 0x0F (test) select the boundary-control register (`dsel`=3).
- R9: The unsupported opcodes 0x03, 0x84, 0x05 and 0x88, and every other even-parity opcode not named in R6 to R8, decode to `dsel`=0 with `mode`=0.
- R10: An opcode with odd parity decodes to `dsel`=0 and `mode`=0, with `parity_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock: shifting on the rising edge, update on the falling edge |
| rst | input | 1 | Synchronous active-high test reset |
| capture_ir | input | 1 | Strobe that loads the capture pattern |
| shift_ir | input | 1 | Strobe that shifts the stage by one bit |
| update_ir | input | 1 | Strobe that latches and decodes the stage |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (stage LSB) |
| dsel | output | 2 | Data register select: 0 bypass, 1 boundary, 2 identification, 3 boundary control |
| mode | output | 2 | Operating mode: 0 normal, 1 test, 2 modified test |
| parity_ok | output | 1 | Latched opcode has even parity |

## Verification
A wrong bit in the shift stage shows on `tdo` at the shift that brings it to bit 0, which is at most eight rising edges after capture. A wrong latched decode shows on `dsel` and `mode` at the falling edge of the same update. A decode that changes outside an update, or a reset that fails, shows at the next falling edge. The bench sweeps all 256 opcodes, so a single wrong table entry or parity slip is seen on the first update that loads that opcode.

// File: rtl/scan_ir_pkg.sv
package scan_ir_pkg;
  localparam int IR_W = 8;

  typedef enum logic [1:0] {
    DSEL_BYPASS = 2'd0,
    DSEL_BOUND  = 2'd1,
    DSEL_IDENT  = 2'd2,
    DSEL_BCTRL  = 2'd3
  } dsel_e;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_TEST    = 2'd1,
    MODE_MODTEST = 2'd2
  } mode_e;

  typedef struct packed {
    dsel_e dsel;
    mode_e mode;
  } decode_t;

  localparam logic [IR_W-1:0] CAPTURE_PAT = 8'h01;
  localparam logic [IR_W-1:0] RESET_OP    = 8'h81;
endpackage

// File: rtl/ir_shift_stage.sv
module ir_shift_stage #(
  parameter int W = 8,
  parameter logic [W-1:0] CAP = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         sout
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst)          stage_q <= CAP;
    else if (capture) stage_q <= CAP;
    else if (shift)   stage_q <= {din, stage_q[W-1:1]};
  end

  assign q    = stage_q;
  assign sout = stage_q[0];
endmodule

// File: rtl/ir_parity_check.sv
module ir_parity_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] word,
  output logic         even
);
  assign even = ~(^word);
endmodule

// File: rtl/ir_opcode_decode.sv
module ir_opcode_decode
  import scan_ir_pkg::*;
(
  input  logic [IR_W-1:0] opcode,
  input  logic            even,
  output decode_t         dec
);
  always_comb begin
    dec = '{dsel: DSEL_BYPASS, mode: MODE_NORMAL};
    if (even) begin
      case (opcode)
        8'h00: dec = '{dsel: DSEL_BOUND,  mode: MODE_TEST};
        8'h81: dec = '{dsel: DSEL_IDENT,  mode: MODE_NORMAL};
        8'h82: dec = '{dsel: DSEL_BOUND,  mode: MODE_NORMAL};
        8'h06: dec = '{dsel: DSEL_BYPASS, mode: MODE_MODTEST};
        8'h87: dec = '{dsel: DSEL_BYPASS, mode: MODE_TEST};
        8'h09: dec = '{dsel: DSEL_BYPASS, mode: MODE_NORMAL};
        8'h0A: dec = '{dsel: DSEL_BOUND,  mode: MODE_NORMAL};
        8'h8B: dec = '{dsel: DSEL_BOUND,  mode: MODE_TEST};
        8'h0C: dec = '{dsel: DSEL_BOUND,  mode: MODE_NORMAL};
        8'h8D: dec = '{dsel: DSEL_BYPASS, mode: MODE_TEST};
        8'h8E: dec = '{dsel: DSEL_BCTRL,  mode: MODE_NORMAL};
        8'h0F: dec = '{dsel: DSEL_BCTRL,  mode: MODE_TEST};
        default: dec = '{dsel: DSEL_BYPASS, mode: MODE_NORMAL};
      endcase
    end
  end
endmodule

// File: rtl/scan_instr_decoder.sv
module scan_instr_decoder
  import scan_ir_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       capture_ir,
  input  logic       shift_ir,
  input  logic       update_ir,
  input  logic       tdi,
  output logic       tdo,
  output logic [1:0] dsel,
  output logic [1:0] mode,
  output logic       parity_ok
);
  logic [IR_W-1:0] stage;
  logic            stage_even;
  decode_t         stage_dec;

  decode_t         dec_q;
  logic            even_q;

  ir_shift_stage #(.W(IR_W), .CAP(CAPTURE_PAT)) u_stage (
    .clk     (tck),
    .rst     (rst),
    .capture (capture_ir),
    .shift   (shift_ir),
    .din     (tdi),
    .q       (stage),
    .sout    (tdo)
  );

  ir_parity_check #(.W(IR_W)) u_par (
    .word (stage),
    .even (stage_even)
  );

  ir_opcode_decode u_dec (
    .opcode (stage),
    .even   (stage_even),
    .dec    (stage_dec)
  );

  // Decode registered on the falling edge while in update
  always_ff @(negedge tck) begin
    if (rst) begin
      dec_q  <= '{dsel: DSEL_IDENT, mode: MODE_NORMAL};
      even_q <= ~(^RESET_OP);
    end else if (update_ir) begin
      dec_q  <= stage_dec;
      even_q <= stage_even;
    end
  end

  assign dsel      = dec_q.dsel;
  assign mode      = dec_q.mode;
  assign parity_ok = even_q;
endmodule

// File: rtl/scan_instr_decoder_chk.sv
module scan_instr_decoder_chk (
  input logic       tck,
  input logic       rst,
  input logic       capture_ir,
  input logic       update_ir,
  input logic       tdo,
  input logic [1:0] dsel,
  input logic [1:0] mode,
  input logic       parity_ok
);
  // R1
  capture_lsb_chk: assert property (@(posedge tck) disable iff (rst)
    capture_ir |=> tdo == 1'b1);

  // R3
  hold_outputs_chk: assert property (@(negedge tck) disable iff (rst)
    !update_ir |=> ($stable(dsel) && $stable(mode) && $stable(parity_ok)));

  // R4
  reset_ident_chk: assert property (@(negedge tck)
    rst |=> (dsel == 2'd2 && mode == 2'd0 && parity_ok));

  // R10
  bad_parity_bypass_chk: assert property (@(negedge tck) disable iff (rst)
    !parity_ok |-> (dsel == 2'd0 && mode == 2'd0));

  // R7
  modtest_bypass_chk: assert property (@(negedge tck) disable iff (rst)
    mode == 2'd2 |-> dsel == 2'd0);

  // R8
  ident_normal_chk: assert property (@(negedge tck) disable iff (rst)
    dsel == 2'd2 |-> mode == 2'd0);
endmodule

bind scan_instr_decoder scan_instr_decoder_chk u_chk (
  .tck        (tck),
  .rst        (rst),
  .capture_ir (capture_ir),
  .update_ir  (update_ir),
  .tdo        (tdo),
  .dsel       (dsel),
  .mode       (mode),
  .parity_ok  (parity_ok)
);

// File: tb/scan_instr_decoder_test.sv
module scan_instr_decoder_test;
  logic       tck = 1'b0;
  logic       rst = 1'b1;
  logic       capture_ir = 1'b0;
  logic       shift_ir = 1'b0;
  logic       update_ir = 1'b0;
  logic       tdi = 1'b0;
  logic       tdo;
  logic [1:0] dsel;
  logic [1:0] mode;
  logic       parity_ok;

  int tests = 0;
  int fails = 0;

  always #4 tck = ~tck;

  scan_instr_decoder uut (
    .tck(tck), .rst(rst), .capture_ir(capture_ir), .shift_ir(shift_ir),
    .update_ir(update_ir), .tdi(tdi), .tdo(tdo), .dsel(dsel),
    .mode(mode), .parity_ok(parity_ok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {dsel, mode, parity_ok}
  function automatic logic [4:0] ref_dec(input logic [7:0] op);
    logic [1:0] d = 2'd0;
    logic [1:0] m = 2'd0;
    if (^op) return 5'b00000;
    case (op)
      8'h00: begin d = 1; m = 1; end
      8'h82, 8'h0A, 8'h0C: begin d = 1; m = 0; end
      8'h8B: begin d = 1; m = 1; end
      8'h06: begin d = 0; m = 2; end
      8'h87, 8'h8D: begin d = 0; m = 1; end
      8'h81: begin d = 2; m = 0; end
      8'h8E: begin d = 3; m = 0; end
      8'h0F: begin d = 3; m = 1; end
      default: begin d = 0; m = 0; end
    endcase
    return {d, m, 1'b1};
  endfunction

  task automatic shift8(input logic do_cap, input logic [7:0] din, output logic [7:0] dout);
    if (do_cap) begin
      capture_ir = 1'b1;
      @(posedge tck); #1;
      capture_ir = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      shift_ir = 1'b1;
      tdi = din[i];
      dout[i] = tdo;
      @(posedge tck); #1;
    end
    shift_ir = 1'b0;
  endtask

  task automatic do_update();
    update_ir = 1'b1;
    @(negedge tck); #1;
    update_ir = 1'b0;
  endtask

  task automatic load(input logic [7:0] op);
    logic [7:0] dummy;
    shift8(1'b1, op, dummy);
    do_update();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge tck);
    #1 rst = 1'b0;
    chk("R4 dsel", {6'd0, dsel}, 8'd2);
    chk("R4 mode", {6'd0, mode}, 8'd0);
    chk("R4 parity_ok", {7'd0, parity_ok}, 8'd1);
  endtask

  task automatic t_capture_and_shift();
    logic [7:0] out1, out2;
    shift8(1'b1, 8'hA5, out1);
    chk("R1 capture pattern", out1, 8'h01);
    shift8(1'b0, 8'h3C, out2);
    chk("R2 shift-through", out2, 8'hA5);
  endtask

  task automatic t_hold();
    logic [7:0] dummy;
    load(8'h00);
    chk("R6 0x00 dsel", {6'd0, dsel}, 8'd1);
    shift8(1'b1, 8'h81, dummy);
    chk("R3 dsel held", {6'd0, dsel}, 8'd1);
    chk("R3 mode held", {6'd0, mode}, 8'd1);
    repeat (3) @(posedge tck);
    #1 chk("R3 held idle", {4'd0, dsel, mode}, 8'b0101);
    do_update();
    chk("R8 0x81 after update", {4'd0, dsel, mode}, 8'b1000);
  endtask

  task automatic t_named();
    logic [7:0] ops [14] = '{8'h00, 8'h82, 8'h0A, 8'h8B, 8'h0C, 8'h06, 8'h87,
                             8'h09, 8'h8D, 8'h81, 8'h8E, 8'h0F, 8'h03, 8'h88};
    for (int i = 0; i < 14; i++) begin
      load(ops[i]);
      chk("R6 R7 R8 R9 named opcode", {3'd0, dsel, mode, parity_ok}, {3'd0, ref_dec(ops[i])});
    end
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 256; op++) begin
      load(op[7:0]);
      if (^op[7:0]) begin
        chk("R10 odd parity", {3'd0, dsel, mode, parity_ok}, 8'd0);
      end else begin
        chk("R5 R9 even opcode", {3'd0, dsel, mode, parity_ok}, {3'd0, ref_dec(op[7:0])});
      end
    end
  endtask

  task automatic t_reset_mid();
    load(8'h06);
    chk("R7 0x06 modified test", {4'd0, dsel, mode}, 8'b0010);
    t_reset();
    load(8'h84);
    chk("R9 0x84 unsupported", {3'd0, dsel, mode, parity_ok}, 8'b00001);
    load(8'h01);
    chk("R10 0x01 bad parity", {7'd0, parity_ok}, 8'd0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_capture_and_shift();
    t_hold();
    t_named();
    t_sweep();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule